// File: doc/BRIEF.md
# Reorder Buffer with Precise Exceptions

This block keeps instructions in program order while they execute out of order. Each issued instruction claims the next slot of a circular buffer and learns its slot index from `alloc_idx`. Execution units later report completion by index, in any order, and may flag an exception. The buffer retires finished work strictly from the oldest end, up to `RETIRE_W` entries per cycle. Each retired entry presents its destination tag to the commit logic.

Every entry can be marked speculative and labelled with a branch tag. A branch outcome arrives with the slot index of the branch and its tag. A correct outcome makes every entry with that tag non-speculative. A wrong outcome discards everything younger than the branch and rewinds allocation to the slot just after it. When the oldest entry has finished with an exception and is no longer speculative, the buffer raises a one-cycle flush, reports that entry's destination tag and empties itself. The faulting entry is not committed, and all older work has already retired.

Top module: `reorder_buf`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `alloc_idx` is 0, `ret_valid` is all zero and `flush` is 0.
- R2: Successive accepted allocations receive slot indices that increase by one modulo DEPTH. With DEPTH entries held, `alloc_ready` is 0 and a request is dropped without changing any state.
- R3: An entry retires only once it has been reported complete, is not speculative and carries no exception. A completion reported in one cycle can produce retirement in the next cycle at the earliest. Each retiring slot presents the destination tag written at allocation.
- R4: Retirement is in order and takes at most RETIRE_W entries per cycle. Slot k of `ret_valid` (bit k) is set only if slots 0..k-1 are also set, and slot k carries the entry k places after the oldest.
- R5: A correct branch outcome (`br_valid`=1, `br_mispredict`=0) clears the speculative mark of every held entry whose branch tag equals `br_tag`. This includes an entry allocated in the same cycle with that tag.
- R6: A wrong branch outcome (`br_valid`=1, `br_mispredict`=1) removes every entry younger than slot `br_idx`. The next allocation then receives index `br_idx`+1 modulo DEPTH. Entries from the oldest up to the branch stay, and they may retire in the same cycle.
- R7: When the oldest entry is complete, not speculative and excepting, `flush` is 1 for exactly that cycle, `exc_dest` shows its destination tag and `ret_valid` is zero. Afterwards the buffer is empty, and the next allocation reuses the faulting slot index.
- R8: In a cycle with `flush` high or with a wrong branch outcome, `alloc_ready` is 0 and an allocation request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Request to record a newly issued instruction |
| alloc_dest | input | DEST_W | Destination tag of the new instruction |
| alloc_spec | input | 1 | New instruction lies behind an unresolved branch |
| alloc_btag | input | BTAG_W | Branch tag the new instruction depends on |
| alloc_ready | output | 1 | A request in this cycle is accepted |
| alloc_idx | output | $clog2(DEPTH) | Slot index given to an accepted request |
| cmpl_valid | input | 1 | Completion report |
| cmpl_idx | input | $clog2(DEPTH) | Slot index of the completed instruction |
| cmpl_exc | input | 1 | The completed instruction raised an exception |
| br_valid | input | 1 | Branch outcome report |
| br_mispredict | input | 1 | Outcome differs from the prediction |
| br_idx | input | $clog2(DEPTH) | Slot index of the resolved branch |
| br_tag | input | BTAG_W | Tag carried by entries that depend on the branch |
| ret_valid | output | RETIRE_W | Per-slot retirement strobe, slot 0 oldest |
| ret_dest | output | RETIRE_W*DEST_W | Destination tags of retiring slots, slot k at bits k*DEST_W upward |
| flush | output | 1 | Precise exception: all held entries discarded |
| exc_dest | output | DEST_W | Destination tag of the faulting entry while flush is high |

## Verification
A wrong head pointer or occupancy count shows up within one cycle. The retirement strobes then name the wrong slot or the wrong destination tag, or `alloc_idx` departs from the expected sequence at the next allocation. A lost completion or a speculative mark that stays set causes no wrong output at first. It only stalls retirement, which the port comparison catches in the first cycle the entry should have retired. A faulty squash length becomes visible at the next allocation index and again when discarded entries would retire, so the directed cases check the rewind before any new allocation hides it.

// File: rtl/rob_pkg.sv
package rob_pkg;

   // Per-slot status flags held beside the destination tag.
   typedef struct packed {
      logic done;
      logic exc;
      logic spec;
   } rob_stat_t;

   // What the oldest entry does in the current cycle.
   typedef enum logic [1:0] {
      HD_WAIT   = 2'd0,
      HD_RETIRE = 2'd1,
      HD_FLUSH  = 2'd2
   } head_act_e;

   // True when a held entry may leave the buffer normally.
   function automatic logic stat_retirable(input rob_stat_t s);
      return s.done && !s.spec && !s.exc;
   endfunction

   // True when a held entry must trigger a precise flush at the head.
   function automatic logic stat_faulting(input rob_stat_t s);
      return s.done && s.exc && !s.spec;
   endfunction

endpackage

// File: rtl/rob_entry_array.sv
module rob_entry_array
   import rob_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int DEST_W = 6,
   parameter int BTAG_W = 3,
   parameter int IDX_W  = $clog2(DEPTH)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         alloc_we,
   input  logic [IDX_W-1:0]             alloc_idx,
   input  logic [DEST_W-1:0]            alloc_dest,
   input  logic                         alloc_spec,
   input  logic [BTAG_W-1:0]            alloc_btag,
   input  logic                         cmpl_we,
   input  logic [IDX_W-1:0]             cmpl_idx,
   input  logic                         cmpl_exc,
   input  logic                         res_we,
   input  logic [BTAG_W-1:0]            res_tag,
   output logic [DEPTH-1:0][DEST_W-1:0] dest_q,
   output rob_stat_t [DEPTH-1:0]        stat_q
);

   // An allocation that arrives with its own branch already confirmed
   // starts out non-speculative.
   logic alloc_spec_eff;
   assign alloc_spec_eff = alloc_spec && !(res_we && (alloc_btag == res_tag));

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [DEST_W-1:0] dest_r;
      logic [BTAG_W-1:0] btag_r;
      rob_stat_t         stat_r;
      logic              hit_alloc;
      logic              hit_cmpl;
      logic              hit_res;

      assign hit_alloc = alloc_we && (alloc_idx == IDX_W'(g));
      assign hit_cmpl  = cmpl_we  && (cmpl_idx  == IDX_W'(g));
      assign hit_res   = res_we   && (btag_r    == res_tag);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dest_r <= '0;
            btag_r <= '0;
            stat_r <= '0;
         end else if (hit_alloc) begin
            dest_r      <= alloc_dest;
            btag_r      <= alloc_btag;
            stat_r.done <= 1'b0;
            stat_r.exc  <= 1'b0;
            stat_r.spec <= alloc_spec_eff;
         end else begin
            if (hit_cmpl) begin
               stat_r.done <= 1'b1;
               stat_r.exc  <= cmpl_exc;
            end
            if (hit_res) begin
               stat_r.spec <= 1'b0;
            end
         end
      end

      assign dest_q[g] = dest_r;
      assign stat_q[g] = stat_r;
   end

endmodule

// File: rtl/rob_retire_sel.sv
module rob_retire_sel
   import rob_pkg::*;
#(
   parameter int DEPTH    = 8,
   parameter int DEST_W   = 6,
   parameter int RETIRE_W = 2,
   parameter int IDX_W    = $clog2(DEPTH),
   parameter int CNT_W    = IDX_W + 1
) (
   input  logic [IDX_W-1:0]                head_q,
   input  logic [CNT_W-1:0]                count_q,
   input  logic [CNT_W-1:0]                limit,
   input  logic [DEPTH-1:0][DEST_W-1:0]    dest_q,
   input  rob_stat_t [DEPTH-1:0]           stat_q,
   output logic [RETIRE_W-1:0]             ret_valid,
   output logic [RETIRE_W-1:0][DEST_W-1:0] ret_dest,
   output logic [CNT_W-1:0]                n_ret,
   output head_act_e                       head_act,
   output logic [DEST_W-1:0]               exc_dest
);

   // chain[k] is set when every slot older than k retires this cycle.
   logic [RETIRE_W:0] chain;
   assign chain[0] = 1'b1;

   for (genvar k = 0; k < RETIRE_W; k++) begin : g_port
      logic [IDX_W-1:0] sidx;
      rob_stat_t        st;
      logic             ok;

      assign sidx = head_q + IDX_W'(k);
      assign st   = stat_q[sidx];
      assign ok   = chain[k] && (CNT_W'(k) < limit) && stat_retirable(st);

      assign chain[k+1]   = ok;
      assign ret_valid[k] = ok;
      assign ret_dest[k]  = dest_q[sidx];
   end

   if (RETIRE_W == 1) begin : g_single
      assign n_ret = CNT_W'(ret_valid[0]);
   end else begin : g_multi
      always_comb begin
         n_ret = '0;
         for (int k = 0; k < RETIRE_W; k++) begin
            n_ret = n_ret + CNT_W'(ret_valid[k]);
         end
      end
   end

   rob_stat_t head_st;
   assign head_st  = stat_q[head_q];
   assign exc_dest = dest_q[head_q];

   always_comb begin
      if ((count_q != '0) && stat_faulting(head_st)) begin
         head_act = HD_FLUSH;
      end else if (ret_valid[0]) begin
         head_act = HD_RETIRE;
      end else begin
         head_act = HD_WAIT;
      end
   end

endmodule

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
   parameter int DEPTH = 8,
   parameter int IDX_W = $clog2(DEPTH),
   parameter int CNT_W = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_fire,
   input  logic [CNT_W-1:0] n_ret,
   input  logic             flush,
   input  logic             squash,
   input  logic [IDX_W-1:0] br_idx,
   output logic [IDX_W-1:0] head_q,
   output logic [IDX_W-1:0] tail_q,
   output logic [CNT_W-1:0] count_q,
   output logic [CNT_W-1:0] squash_len
);

   // Entries kept by a squash: oldest through the branch itself.
   logic [IDX_W-1:0] gap;
   assign gap        = br_idx - head_q;
   assign squash_len = CNT_W'(gap) + CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= '0;
      end else if (flush) begin
         tail_q  <= head_q;
         count_q <= '0;
      end else if (squash) begin
         head_q  <= head_q + IDX_W'(n_ret);
         tail_q  <= br_idx + 1'b1;
         count_q <= squash_len - n_ret;
      end else begin
         head_q  <= head_q + IDX_W'(n_ret);
         tail_q  <= tail_q + IDX_W'(alloc_fire);
         count_q <= count_q + CNT_W'(alloc_fire) - n_ret;
      end
   end

endmodule

// File: rtl/reorder_buf.sv
module reorder_buf
   import rob_pkg::*;
#(
   parameter  int DEPTH    = 8,
   parameter  int DEST_W   = 6,
   parameter  int BTAG_W   = 3,
   parameter  int RETIRE_W = 2,
   localparam int IDX_W    = $clog2(DEPTH),
   localparam int CNT_W    = IDX_W + 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       alloc_valid,
   input  logic [DEST_W-1:0]          alloc_dest,
   input  logic                       alloc_spec,
   input  logic [BTAG_W-1:0]          alloc_btag,
   output logic                       alloc_ready,
   output logic [IDX_W-1:0]           alloc_idx,
   input  logic                       cmpl_valid,
   input  logic [IDX_W-1:0]           cmpl_idx,
   input  logic                       cmpl_exc,
   input  logic                       br_valid,
   input  logic                       br_mispredict,
   input  logic [IDX_W-1:0]           br_idx,
   input  logic [BTAG_W-1:0]          br_tag,
   output logic [RETIRE_W-1:0]        ret_valid,
   output logic [RETIRE_W*DEST_W-1:0] ret_dest,
   output logic                       flush,
   output logic [DEST_W-1:0]          exc_dest
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("reorder_buf: DEPTH must be a power of two of at least 2");
   end
   if (RETIRE_W < 1 || RETIRE_W > DEPTH) begin : g_bad_retire
      $error("reorder_buf: RETIRE_W must lie between 1 and DEPTH");
   end
   if (DEST_W < 1 || BTAG_W < 1) begin : g_bad_width
      $error("reorder_buf: tag widths must be positive");
   end

   logic [IDX_W-1:0]                head_q;
   logic [IDX_W-1:0]                tail_q;
   logic [CNT_W-1:0]                count_q;
   logic [CNT_W-1:0]                squash_len;
   logic [CNT_W-1:0]                retire_limit;
   logic [CNT_W-1:0]                n_ret;
   logic                            squash;
   logic                            alloc_fire;
   logic                            flush_now;
   head_act_e                       head_act;
   logic [DEPTH-1:0][DEST_W-1:0]    dest_q;
   rob_stat_t [DEPTH-1:0]           stat_q;
   logic [RETIRE_W-1:0][DEST_W-1:0] slot_dest;

   assign squash       = br_valid && br_mispredict;
   assign flush_now    = (head_act == HD_FLUSH);
   assign alloc_ready  = (count_q != CNT_W'(DEPTH)) && !flush_now && !squash;
   assign alloc_fire   = alloc_valid && alloc_ready;
   assign alloc_idx    = tail_q;
   // During a squash only entries up to the branch may retire.
   assign retire_limit = squash ? squash_len : count_q;
   assign ret_dest     = slot_dest;
   assign flush        = flush_now;

   rob_entry_array #(
      .DEPTH  (DEPTH),
      .DEST_W (DEST_W),
      .BTAG_W (BTAG_W),
      .IDX_W  (IDX_W)
   ) u_array (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_we   (alloc_fire),
      .alloc_idx  (tail_q),
      .alloc_dest (alloc_dest),
      .alloc_spec (alloc_spec),
      .alloc_btag (alloc_btag),
      .cmpl_we    (cmpl_valid),
      .cmpl_idx   (cmpl_idx),
      .cmpl_exc   (cmpl_exc),
      .res_we     (br_valid && !br_mispredict),
      .res_tag    (br_tag),
      .dest_q     (dest_q),
      .stat_q     (stat_q)
   );

   rob_retire_sel #(
      .DEPTH    (DEPTH),
      .DEST_W   (DEST_W),
      .RETIRE_W (RETIRE_W),
      .IDX_W    (IDX_W),
      .CNT_W    (CNT_W)
   ) u_retire (
      .head_q    (head_q),
      .count_q   (count_q),
      .limit     (retire_limit),
      .dest_q    (dest_q),
      .stat_q    (stat_q),
      .ret_valid (ret_valid),
      .ret_dest  (slot_dest),
      .n_ret     (n_ret),
      .head_act  (head_act),
      .exc_dest  (exc_dest)
   );

   rob_ptr_ctrl #(
      .DEPTH (DEPTH),
      .IDX_W (IDX_W),
      .CNT_W (CNT_W)
   ) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_fire (alloc_fire),
      .n_ret      (n_ret),
      .flush      (flush_now),
      .squash     (squash),
      .br_idx     (br_idx),
      .head_q     (head_q),
      .tail_q     (tail_q),
      .count_q    (count_q),
      .squash_len (squash_len)
   );

endmodule

// File: rtl/reorder_buf_chk.sv
module reorder_buf_chk #(
   parameter int DEPTH    = 8,
   parameter int RETIRE_W = 2,
   parameter int CNT_W    = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                alloc_ready,
   input logic                br_valid,
   input logic                br_mispredict,
   input logic [RETIRE_W-1:0] ret_valid,
   input logic                flush,
   input logic [CNT_W-1:0]    count
);

   a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   a_r2_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_W'(DEPTH)) |-> !alloc_ready);

   a_r4_in_order_slots: assert property (@(posedge clk) disable iff (!rst_n)
      ((ret_valid + RETIRE_W'(1)) & ret_valid) == '0);

   a_r7_flush_no_retire: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> (ret_valid == '0));

   a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count == '0));

   a_r7_flush_single: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !flush);

   a_r8_squash_blocks_alloc: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && br_mispredict) |-> !alloc_ready);

   a_r8_flush_blocks_alloc: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !alloc_ready);

endmodule

bind reorder_buf reorder_buf_chk #(
   .DEPTH    (DEPTH),
   .RETIRE_W (RETIRE_W),
   .CNT_W    (CNT_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .alloc_ready   (alloc_ready),
   .br_valid      (br_valid),
   .br_mispredict (br_mispredict),
   .ret_valid     (ret_valid),
   .flush         (flush),
   .count         (count_q)
);

// File: tb/reorder_buf_tb.sv
module reorder_buf_tb;

   localparam int D  = 8;
   localparam int DW = 6;
   localparam int BW = 3;
   localparam int RW = 2;
   localparam int IW = $clog2(D);

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic               rst_n;
   logic               alloc_valid;
   logic [DW-1:0]      alloc_dest;
   logic               alloc_spec;
   logic [BW-1:0]      alloc_btag;
   logic               alloc_ready;
   logic [IW-1:0]      alloc_idx;
   logic               cmpl_valid;
   logic [IW-1:0]      cmpl_idx;
   logic               cmpl_exc;
   logic               br_valid;
   logic               br_mispredict;
   logic [IW-1:0]      br_idx;
   logic [BW-1:0]      br_tag;
   logic [RW-1:0]      ret_valid;
   logic [RW*DW-1:0]   ret_dest;
   logic               flush;
   logic [DW-1:0]      exc_dest;

   reorder_buf #(.DEPTH(D), .DEST_W(DW), .BTAG_W(BW), .RETIRE_W(RW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_dest(alloc_dest), .alloc_spec(alloc_spec),
      .alloc_btag(alloc_btag), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
      .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx), .cmpl_exc(cmpl_exc),
      .br_valid(br_valid), .br_mispredict(br_mispredict), .br_idx(br_idx), .br_tag(br_tag),
      .ret_valid(ret_valid), .ret_dest(ret_dest), .flush(flush), .exc_dest(exc_dest)
   );

   int n_chk = 0;
   int n_err = 0;

   // Reference model of the buffer contents.
   logic [DW-1:0] m_dest [D];
   logic          m_done [D];
   logic          m_exc  [D];
   logic          m_spec [D];
   logic [BW-1:0] m_btag [D];
   int            m_head;
   int            m_count;
   logic          last_squash;

   // Expected values for the current cycle.
   logic          e_ready;
   int            e_idx;
   logic [RW-1:0] e_rv;
   logic          e_flush;
   logic [DW-1:0] e_exc_dest;
   int            e_nret;
   int            e_limit;

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < D; i++) begin
         m_dest[i] = '0; m_done[i] = 1'b0; m_exc[i] = 1'b0;
         m_spec[i] = 1'b0; m_btag[i] = '0;
      end
      m_head = 0;
      m_count = 0;
      last_squash = 1'b0;
   endtask

   task automatic predict(input logic br, input logic mis, input int bidx);
      logic chain;
      int   idx;
      e_flush = (m_count > 0) && m_done[m_head] && m_exc[m_head] && !m_spec[m_head];
      e_limit = (br && mis) ? (((bidx - m_head + D) % D) + 1) : m_count;
      chain   = 1'b1;
      e_nret  = 0;
      e_rv    = '0;
      for (int k = 0; k < RW; k++) begin
         idx   = (m_head + k) % D;
         chain = chain && (k < e_limit) && m_done[idx] && !m_spec[idx] && !m_exc[idx];
         e_rv[k] = chain;
         if (chain) e_nret++;
      end
      e_exc_dest = m_dest[m_head];
      e_ready    = (m_count < D) && !e_flush && !(br && mis);
      e_idx      = (m_head + m_count) % D;
   endtask

   task automatic commit(input logic alloc, input logic [DW-1:0] dest, input logic spec,
                         input logic [BW-1:0] btag, input logic cv, input int cidx,
                         input logic cexc, input logic br, input logic mis, input int bidx,
                         input logic [BW-1:0] btg);
      int   tail;
      logic fire;
      tail = (m_head + m_count) % D;
      fire = alloc && e_ready;
      if (br && !mis) begin
         for (int i = 0; i < D; i++) if (m_btag[i] == btg) m_spec[i] = 1'b0;
      end
      if (cv) begin
         m_done[cidx] = 1'b1;
         m_exc[cidx]  = cexc;
      end
      if (fire) begin
         m_dest[tail] = dest; m_btag[tail] = btag;
         m_done[tail] = 1'b0; m_exc[tail] = 1'b0;
         m_spec[tail] = spec && !(br && !mis && (btag == btg));
      end
      if (e_flush) begin
         m_count = 0;
      end else if (br && mis) begin
         m_count = e_limit - e_nret;
         m_head  = (m_head + e_nret) % D;
      end else begin
         m_count = m_count + (fire ? 1 : 0) - e_nret;
         m_head  = (m_head + e_nret) % D;
      end
      last_squash = br && mis && !e_flush;
   endtask

   task automatic step(input logic alloc, input logic [DW-1:0] dest, input logic spec,
                       input logic [BW-1:0] btag, input logic cv, input int cidx,
                       input logic cexc, input logic br, input logic mis, input int bidx,
                       input logic [BW-1:0] btg);
      @(negedge clk);
      alloc_valid = alloc; alloc_dest = dest; alloc_spec = spec; alloc_btag = btag;
      cmpl_valid = cv; cmpl_idx = IW'(cidx); cmpl_exc = cexc;
      br_valid = br; br_mispredict = mis; br_idx = IW'(bidx); br_tag = btg;
      #1;
      predict(br, mis, bidx);
      chk((e_flush || (br && mis)) ? "R8" : "R2", "alloc_ready", 64'(alloc_ready), 64'(e_ready));
      if (e_ready) chk(last_squash ? "R6" : "R2", "alloc_idx", 64'(alloc_idx), 64'(e_idx));
      chk((br && !mis) ? "R5" : "R4", "ret_valid", 64'(ret_valid), 64'(e_rv));
      for (int k = 0; k < RW; k++) begin
         if (e_rv[k]) chk("R3", "ret_dest", 64'(ret_dest[k*DW +: DW]), 64'(m_dest[(m_head + k) % D]));
      end
      chk("R7", "flush", 64'(flush), 64'(e_flush));
      if (e_flush) chk("R7", "exc_dest", 64'(exc_dest), 64'(e_exc_dest));
      commit(alloc, dest, spec, btag, cv, cidx, cexc, br, mis, bidx, btg);
   endtask

   task automatic idle();
      step(1'b0, '0, 1'b0, '0, 1'b0, 0, 1'b0, 1'b0, 1'b0, 0, '0);
   endtask

   task automatic do_alloc(input logic [DW-1:0] dest, input logic spec, input logic [BW-1:0] btag);
      step(1'b1, dest, spec, btag, 1'b0, 0, 1'b0, 1'b0, 1'b0, 0, '0);
   endtask

   task automatic do_cmpl(input int idx, input logic exc);
      step(1'b0, '0, 1'b0, '0, 1'b1, idx, exc, 1'b0, 1'b0, 0, '0);
   endtask

   task automatic do_branch(input logic mis, input int idx, input logic [BW-1:0] tag, input logic try_alloc);
      step(try_alloc, 6'd63, 1'b1, tag, 1'b0, 0, 1'b0, 1'b1, mis, idx, tag);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'd2718));
      rst_n = 1'b0;
      alloc_valid = 0; alloc_dest = '0; alloc_spec = 0; alloc_btag = '0;
      cmpl_valid = 0; cmpl_idx = '0; cmpl_exc = 0;
      br_valid = 0; br_mispredict = 0; br_idx = '0; br_tag = '0;
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: empty after reset
      chk("R1", "alloc_ready", 64'(alloc_ready), 64'd1);
      chk("R1", "alloc_idx", 64'(alloc_idx), 64'd0);
      chk("R1", "ret_valid", 64'(ret_valid), 64'd0);
      chk("R1", "flush", 64'(flush), 64'd0);
      rst_n = 1'b1;

      // R2: fill to capacity, then a ninth request is refused
      for (int i = 0; i < D; i++) do_alloc(DW'(10 + i), 1'b0, '0);
      do_alloc(6'd40, 1'b0, '0);
      // R3 and R4: out-of-order completion, paired in-order retirement
      do_cmpl(3, 1'b0);
      do_cmpl(1, 1'b0);
      do_cmpl(0, 1'b0);
      idle();
      do_cmpl(2, 1'b0);
      idle();
      // R7: exception at slot 5 flushes after slot 4 retires
      do_cmpl(5, 1'b1);
      do_cmpl(4, 1'b0);
      idle();
      idle();
      idle();
      // R6 and R8: wrong branch at slot 5 discards the younger entries
      do_alloc(6'd20, 1'b0, '0);
      do_alloc(6'd21, 1'b1, 3'd2);
      do_alloc(6'd22, 1'b1, 3'd2);
      do_alloc(6'd23, 1'b1, 3'd2);
      do_branch(1'b1, 5, 3'd2, 1'b1);
      do_alloc(6'd24, 1'b0, '0);
      // R5: speculative entries wait, then a correct outcome releases them
      do_alloc(6'd25, 1'b1, 3'd3);
      do_alloc(6'd26, 1'b1, 3'd3);
      do_cmpl(5, 1'b0);
      do_cmpl(6, 1'b0);
      do_cmpl(7, 1'b0);
      do_cmpl(0, 1'b0);
      idle();
      do_branch(1'b0, 7, 3'd3, 1'b1);
      idle();
      idle();

      // Random traffic mixed with the model
      for (int cyc = 0; cyc < 4000; cyc++) begin
         logic          a, sp, cv, ce, br, mis;
         logic [DW-1:0] dst;
         logic [BW-1:0] bt, btg;
         int            ci, bi;
         a   = ($urandom_range(0, 9) < 6);
         dst = DW'($urandom);
         sp  = ($urandom_range(0, 9) < 3);
         bt  = BW'($urandom);
         cv  = 1'b0; ci = 0; ce = 1'b0;
         if (m_count > 0 && $urandom_range(0, 1) == 1) begin
            ci = (m_head + $urandom_range(0, m_count - 1)) % D;
            if (!m_done[ci]) begin
               cv = 1'b1;
               ce = ($urandom_range(0, 11) == 0);
            end
         end
         br = 1'b0; mis = 1'b0; bi = 0; btg = BW'($urandom);
         if (m_count > 0 && $urandom_range(0, 99) < 12) begin
            br  = 1'b1;
            mis = ($urandom_range(0, 9) < 4);
            bi  = (m_head + $urandom_range(0, m_count - 1)) % D;
         end
         step(a, dst, sp, bt, cv, ci, ce, br, mis, bi, btg);
      end
      idle();
      finish_run();
   end

endmodule